// File: doc/BRIEF.md
# Trim Parameter Register and One-Time Fuse Controller

This block carries out trim commands that have already been checked and decoded. Each command has a 2-bit function, a 2-bit parameter selector and an 8-bit value. The block keeps four trim fields in two copies:

- **Shadow registers:** volatile registers that can be rewritten at will.
- **Fuse bits:** one-time-programmable bits, modelled as sticky flip-flops that can only be set.

The four fields are the second-stage gain code, the first-stage gain code, the output offset code and a control field. The control field holds a master fuse and a production-test fuse.

The trim outputs follow the shadow registers until the master fuse is blown. From then on they follow the fuse bits. A read command returns the effective value of one field on an 8-bit port. A sense-current command only raises a one-cycle strobe for the surrounding logic.

A command is accepted in the `IDLE` state when `cmd_valid` and `cmd_ready` are both high. The function code selects one of four execute states, each lasting one cycle:

| Function code | Execute state | Action |
|---|---|---|
| 00 | `SENSE` | raise `sense_pulse` |
| 01 | `SIM` | write the shadow register |
| 10 | `PROG` | OR the value into the fuse bits |
| 11 | `READ` | drive `rd_data` with `rd_valid` |

Every execute state returns to `IDLE` on the next edge. These are the only states and transitions.

Top module: `trim_fuse_ctrl`

## Requirements
- R1: After reset all trim outputs, `master_blown`, `test_fuse`, `rd_valid`, `rd_data` and `sense_pulse` are 0, and `cmd_ready` is 1.
- R2: Function 01 writes the masked value into the shadow register of the selected field. The parameter codes are 00 = second-stage gain, 01 = first-stage gain, 10 = offset and 11 = control. While the master fuse is intact, the trim outputs show the new value from the second clock edge after acceptance.
- R3: Each field keeps only its low bits: second-stage gain 3 bits, first-stage gain 7 bits, offset 8 bits, control 2 bits. Higher value bits are ignored and read back as 0.
- R4: Function 10 ORs the masked value into the selected fuse bits. No command ever clears a fuse bit.
- R5: The master fuse is control bit 0 and appears on `master_blown`. While it is intact, programmed fuse values do not affect the trim outputs. Once it is blown, the trim outputs and `test_fuse` come from the fuse bits, and shadow writes no longer change them.
- R6: Function 11 raises `rd_valid` for exactly one cycle, the cycle after acceptance. `rd_data` then carries the effective value of the selected field, zero-extended. Control bit 0 of that value always comes from the fuse. `rd_data` is 0 whenever `rd_valid` is low.
- R7: Function 00 raises `sense_pulse` for the one cycle after acceptance and changes no stored field.
- R8: `cmd_ready` is low in the cycle after an accepted command and high again in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; also models the power-on state of an unprogrammed part |
| cmd_valid | input | 1 | A command is present |
| cmd_ready | output | 1 | The block is in `IDLE` and can accept a command |
| cmd_func | input | 2 | Function code: 00 sense, 01 simulate, 10 program, 11 read |
| cmd_param | input | 2 | Field selector |
| cmd_value | input | 8 | Value to write or program |
| gain2_code | output | 3 | Effective second-stage gain code |
| gain1_code | output | 7 | Effective first-stage gain code |
| offset_code | output | 8 | Effective output offset code |
| master_blown | output | 1 | Master fuse state |
| test_fuse | output | 1 | Effective production-test bit |
| rd_valid | output | 1 | Read result strobe |
| rd_data | output | 8 | Read result |
| sense_pulse | output | 1 | Sense-current request strobe |

## Verification
Suppose a command is accepted at edge k. Then `rd_valid`, `rd_data`, `sense_pulse` and the low `cmd_ready` belong to the cycle that follows edge k. The stored fields, and so the trim outputs, change only at edge k+1. The driver therefore samples the strobes at the falling edge just after acceptance, and the trim outputs at the falling edge one cycle later. Expected read values are pushed into a queue before the command is driven. A monitor compares each `rd_valid` beat against the head of that queue, which keeps read checks tied to the strobe and not to a fixed delay.

// File: rtl/trim_pkg.sv
package trim_pkg;
    localparam int VAL_W    = 8;
    localparam int N_FIELDS = 4;
    localparam int SEL_W    = $clog2(N_FIELDS);

    typedef enum logic [1:0] {
        FN_SENSE = 2'b00,
        FN_SIM   = 2'b01,
        FN_PROG  = 2'b10,
        FN_READ  = 2'b11
    } trim_func_e;

    typedef enum logic [1:0] {
        FLD_GAIN2  = 2'b00,
        FLD_GAIN1  = 2'b01,
        FLD_OFFSET = 2'b10,
        FLD_CTRL   = 2'b11
    } trim_field_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SENSE,
        ST_SIM,
        ST_PROG,
        ST_READ
    } trim_state_e;
endpackage

// File: rtl/trim_reg_bank.sv
module trim_reg_bank #(
    parameter int VAL_W    = 8,
    parameter int N_FIELDS = 4,
    parameter int SEL_W    = 2,
    parameter logic [N_FIELDS-1:0][VAL_W-1:0] MASKS = '0,
    parameter bit STICKY   = 1'b0
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [SEL_W-1:0]               wr_sel,
    input  logic [VAL_W-1:0]               wr_data,
    output logic [N_FIELDS-1:0][VAL_W-1:0] q
);
    for (genvar i = 0; i < N_FIELDS; i++) begin : g_field
        logic hit;
        assign hit = wr_en && (wr_sel == SEL_W'(i));

        if (STICKY) begin : g_sticky
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)   q[i] <= '0;
                else if (hit) q[i] <= q[i] | (wr_data & MASKS[i]);
            end
            // R4: once set, a fuse bit stays set
            a_r4_fuse_never_clears: assert property (@(posedge clk) disable iff (!rst_n)
                (q[i] & $past(q[i])) == $past(q[i]));
        end else begin : g_plain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)   q[i] <= '0;
                else if (hit) q[i] <= wr_data & MASKS[i];
            end
        end

        // R3: bits above the field width never become set
        a_r3_upper_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
            (q[i] & ~MASKS[i]) == '0);
    end
endmodule

// File: rtl/trim_select.sv
module trim_select #(
    parameter int VAL_W    = 8,
    parameter int N_FIELDS = 4,
    parameter int CTRL_IDX = 3
) (
    input  logic [N_FIELDS-1:0][VAL_W-1:0] shadow,
    input  logic [N_FIELDS-1:0][VAL_W-1:0] fuse,
    output logic [N_FIELDS-1:0][VAL_W-1:0] eff,
    output logic                           master
);
    assign master = fuse[CTRL_IDX][0];

    for (genvar i = 0; i < N_FIELDS; i++) begin : g_sel
        if (i == CTRL_IDX) begin : g_ctrl
            // bit 0 is the master fuse itself and never comes from a shadow copy
            assign eff[i] = {(master ? fuse[i][VAL_W-1:1] : shadow[i][VAL_W-1:1]),
                             fuse[i][0]};
        end else begin : g_data
            assign eff[i] = master ? fuse[i] : shadow[i];
        end
    end
endmodule

// File: rtl/trim_fuse_ctrl.sv
module trim_fuse_ctrl
    import trim_pkg::*;
#(
    parameter int GAIN2_W = 3,
    parameter int GAIN1_W = 7,
    parameter int OFFS_W  = 8,
    parameter int CTRL_W  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    output logic               cmd_ready,
    input  logic [1:0]         cmd_func,
    input  logic [SEL_W-1:0]   cmd_param,
    input  logic [VAL_W-1:0]   cmd_value,
    output logic [GAIN2_W-1:0] gain2_code,
    output logic [GAIN1_W-1:0] gain1_code,
    output logic [OFFS_W-1:0]  offset_code,
    output logic               master_blown,
    output logic               test_fuse,
    output logic               rd_valid,
    output logic [VAL_W-1:0]   rd_data,
    output logic               sense_pulse
);
    localparam int CTRL_IDX = int'(FLD_CTRL);
    localparam logic [N_FIELDS-1:0][VAL_W-1:0] FIELD_MASKS = {
        VAL_W'((1 << CTRL_W) - 1),
        VAL_W'((1 << OFFS_W) - 1),
        VAL_W'((1 << GAIN1_W) - 1),
        VAL_W'((1 << GAIN2_W) - 1)
    };

    trim_state_e                    state_q, state_d;
    logic [SEL_W-1:0]               param_q;
    logic [VAL_W-1:0]               value_q;
    logic                           sh_wr, fu_wr;
    logic [N_FIELDS-1:0][VAL_W-1:0] shadow_q, fuse_q, eff;
    logic                           accept;

    assign accept = cmd_valid && cmd_ready;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    unique case (trim_func_e'(cmd_func))
                        FN_SENSE: state_d = ST_SENSE;
                        FN_SIM:   state_d = ST_SIM;
                        FN_PROG:  state_d = ST_PROG;
                        FN_READ:  state_d = ST_READ;
                    endcase
                end
            end
            ST_SENSE, ST_SIM, ST_PROG, ST_READ: state_d = ST_IDLE;
            default:                            state_d = ST_IDLE;
        endcase
    end

    // command capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            param_q <= '0;
            value_q <= '0;
        end else if (accept) begin
            param_q <= cmd_param;
            value_q <= cmd_value;
        end
    end

    // outputs per state
    always_comb begin
        cmd_ready   = (state_q == ST_IDLE);
        sense_pulse = (state_q == ST_SENSE);
        sh_wr       = (state_q == ST_SIM);
        fu_wr       = (state_q == ST_PROG);
        rd_valid    = (state_q == ST_READ);
        rd_data     = rd_valid ? eff[param_q] : '0;
    end

    trim_reg_bank #(
        .VAL_W(VAL_W), .N_FIELDS(N_FIELDS), .SEL_W(SEL_W),
        .MASKS(FIELD_MASKS), .STICKY(1'b0)
    ) u_shadow (
        .clk(clk), .rst_n(rst_n), .wr_en(sh_wr), .wr_sel(param_q),
        .wr_data(value_q), .q(shadow_q)
    );

    trim_reg_bank #(
        .VAL_W(VAL_W), .N_FIELDS(N_FIELDS), .SEL_W(SEL_W),
        .MASKS(FIELD_MASKS), .STICKY(1'b1)
    ) u_fuse (
        .clk(clk), .rst_n(rst_n), .wr_en(fu_wr), .wr_sel(param_q),
        .wr_data(value_q), .q(fuse_q)
    );

    trim_select #(
        .VAL_W(VAL_W), .N_FIELDS(N_FIELDS), .CTRL_IDX(CTRL_IDX)
    ) u_select (
        .shadow(shadow_q), .fuse(fuse_q), .eff(eff), .master(master_blown)
    );

    assign gain2_code  = eff[int'(FLD_GAIN2)][GAIN2_W-1:0];
    assign gain1_code  = eff[int'(FLD_GAIN1)][GAIN1_W-1:0];
    assign offset_code = eff[int'(FLD_OFFSET)][OFFS_W-1:0];
    assign test_fuse   = eff[CTRL_IDX][1];

    // R6: a read strobe lasts one cycle
    a_r6_read_single_beat: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);
    // R8: every execute state lasts one cycle
    a_r8_busy_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_ready |=> cmd_ready);
    // R7: a sense command leaves the trim outputs untouched
    a_r7_sense_keeps_trims: assert property (@(posedge clk) disable iff (!rst_n)
        sense_pulse |=> ($stable(gain2_code) && $stable(gain1_code) &&
                         $stable(offset_code) && $stable(test_fuse)));
    // R5: once the master fuse is blown, shadow writes are inert
    a_r5_sim_inert_after_blow: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SIM && master_blown) |=>
            ($stable(gain2_code) && $stable(gain1_code) &&
             $stable(offset_code) && $stable(test_fuse)));
    // R4: the master fuse never falls
    a_r4_master_stays: assert property (@(posedge clk) disable iff (!rst_n)
        $past(master_blown) |-> master_blown);
endmodule

// File: tb/sim_trim_fuse_ctrl.sv
module sim_trim_fuse_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic       cmd_ready;
    logic [1:0] cmd_func = '0;
    logic [1:0] cmd_param = '0;
    logic [7:0] cmd_value = '0;
    logic [2:0] gain2_code;
    logic [6:0] gain1_code;
    logic [7:0] offset_code;
    logic       master_blown, test_fuse, rd_valid, sense_pulse;
    logic [7:0] rd_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    trim_fuse_ctrl u0 (.*);

    // bench model built from the requirements
    logic [7:0] sh [4];
    logic [7:0] fu [4];
    logic [7:0] mask [4];
    logic [7:0] exp_q [$];

    function automatic logic [7:0] eff_of(int p);
        logic m;
        m = fu[3][0];
        if (p == 3) return {6'b0, (m ? fu[3][1] : sh[3][1]), fu[3][0]};
        return m ? fu[p] : sh[p];
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_trims(string req);
        check(req, {29'b0, gain2_code}, {29'b0, eff_of(0)[2:0]});
        check(req, {25'b0, gain1_code}, {25'b0, eff_of(1)[6:0]});
        check(req, {24'b0, offset_code}, {24'b0, eff_of(2)});
        check(req, {31'b0, master_blown}, {31'b0, fu[3][0]});
        check(req, {31'b0, test_fuse}, {31'b0, eff_of(3)[1]});
    endtask

    task automatic send(logic [1:0] f, logic [1:0] p, logic [7:0] v, string req);
        @(negedge clk);
        if (f == 2'b11) exp_q.push_back(eff_of(int'(p)));
        cmd_valid = 1'b1; cmd_func = f; cmd_param = p; cmd_value = v;
        @(negedge clk);
        cmd_valid = 1'b0;
        check("R8 busy", {31'b0, cmd_ready}, 32'd0);
        check("R7 sense strobe", {31'b0, sense_pulse}, {31'b0, f == 2'b00});
        if (f == 2'b01) sh[p] = v & mask[p];
        if (f == 2'b10) fu[p] = fu[p] | (v & mask[p]);
        @(negedge clk);
        check("R8 ready again", {31'b0, cmd_ready}, 32'd1);
        check_trims(req);
    endtask

    // monitor: compare read beats against the scoreboard
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) check("R6 unexpected read", 32'd1, 32'd0);
            else check("R6 read data", {24'b0, rd_data}, {24'b0, exp_q.pop_front()});
        end else if (rst_n) begin
            if (rd_data !== 8'h00) check("R6 idle data", {24'b0, rd_data}, 32'd0);
        end
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 4; i++) begin sh[i] = '0; fu[i] = '0; end
        mask[0] = 8'h07; mask[1] = 8'h7F; mask[2] = 8'hFF; mask[3] = 8'h03;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 ready", {31'b0, cmd_ready}, 32'd1);
        check("R1 strobes", {30'b0, rd_valid, sense_pulse}, 32'd0);
        check_trims("R1 reset trims");

        send(2'b01, 2'b00, 8'hFF, "R3 gain2 mask");
        send(2'b01, 2'b01, 8'hFF, "R3 gain1 mask");
        send(2'b01, 2'b10, 8'hA5, "R2 offset write");
        send(2'b11, 2'b00, 8'h00, "R6 read gain2");
        send(2'b11, 2'b01, 8'h00, "R6 read gain1");
        send(2'b00, 2'b10, 8'hFF, "R7 sense no change");
        send(2'b10, 2'b00, 8'h05, "R5 fuse hidden");
        send(2'b10, 2'b10, 8'h3C, "R5 fuse hidden");
        send(2'b10, 2'b00, 8'h02, "R4 fuse OR");
        send(2'b10, 2'b11, 8'hFE, "R3 ctrl test fuse");
        send(2'b11, 2'b11, 8'h00, "R6 read ctrl");
        send(2'b01, 2'b11, 8'hFF, "R5 shadow ctrl");
        send(2'b11, 2'b11, 8'h00, "R6 read ctrl shadow");
        send(2'b10, 2'b11, 8'h01, "R5 master blow");
        send(2'b01, 2'b00, 8'h00, "R5 sim inert");
        send(2'b10, 2'b00, 8'h00, "R4 no clear");
        send(2'b11, 2'b00, 8'h00, "R6 read fuse gain2");
        send(2'b11, 2'b10, 8'h00, "R6 read fuse offset");
        send(2'b11, 2'b11, 8'h00, "R6 read fuse ctrl");
        repeat (2) @(negedge clk);
        check("R6 all reads seen", exp_q.size(), 32'd0);
        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule